// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of small signed weight rows. A hash of the branch address selects one row. Each row has one bias weight and one weight for each bit of a global outcome history. A prediction is the signed dot product of that row with the history, where a history bit of 1 counts as +1 and a bit of 0 counts as -1. The bias input is always +1. The sign of the result gives the direction. Because there is one weight per history bit, storage grows in a straight line with the history length rather than doubling with each extra bit.

A front end raises `pred_valid` with a branch address. One cycle later the block returns the direction, the raw sum, and the history value it used. The caller keeps the sum and the history until the branch resolves. It then presents them, together with the real outcome, on the train port. The block decides whether the row needs training and, if so, moves each weight one step with saturation. Every train request also shifts the real outcome into the global history.

Top module: `perceptron_bp`

## Requirements
- R1: After reset every weight is zero and the history register is all zeros, so the first prediction returns sum 0, taken, and history 0.
- R2: The row for an address is pc[7:2] XOR pc[13:8] (6 bits, 64 rows), so two addresses with equal hash share one weight row.
- R3: The returned sum is the row's bias weight plus, for each k in 0..15, weight k+1 times (+1 if history bit k is 1, else -1).
- R4: The predicted direction is taken exactly when the sum is zero or positive.
- R5: Prediction outputs are registered: `pred_out_valid` is high for exactly the one cycle after each request and low otherwise.
- R6: Each train request shifts its outcome into history bit 0 (older bits move up one place). `pred_hist` returns the history value that the reported sum was computed from.
- R7: A row is trained only when the supplied sum's sign disagrees with the outcome, or when the sum's magnitude is at most 44 (floor(1.93*16+14)). Otherwise the row is left unchanged.
- R8: On training, the bias moves +1 for a taken outcome and -1 for not taken. Weight k+1 moves +1 when history bit k equals the outcome bit, else -1.
- R9: Weights are 8-bit signed and saturate: a step never takes a weight above +127 or below -128.
- R10: When a prediction and a train request land in the same cycle, the prediction uses the weights and history as they were before that training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Prediction request strobe |
| pred_pc | input | 32 | Branch address to predict |
| pred_out_valid | output | 1 | Prediction result valid (one cycle after request) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_sum | output | 13 | Signed dot-product result |
| pred_hist | output | 16 | History used for this prediction |
| train_valid | input | 1 | Resolved-branch strobe |
| train_pc | input | 32 | Address of the resolved branch |
| train_taken | input | 1 | Real outcome, 1 = taken |
| train_sum | input | 13 | Sum reported when the branch was predicted |
| train_hist | input | 16 | History reported when the branch was predicted |

## Verification
The assertions assume that `train_sum` is a signed value that fits the 13-bit port. They make no assumption that it matches the row's current contents, so the block must act only on the value given. They also assume the strobes are only 0 or 1 after reset. The bench normally returns the exact sum and history from an earlier prediction. It also injects chosen sums on purpose (for example -1, 0, 44 and 45) to reach the threshold boundary and the saturation limits. All of these stay inside the port's range.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  // Training margin for a given history length: floor(1.93*n + 14).
  function automatic int theta_of(input int n);
    return (193 * n) / 100 + 14;
  endfunction

  // One saturating step of a signed weight that is wb bits wide.
  function automatic int sat_step(input int w, input logic up, input int wb);
    int hi;
    int lo;
    hi = (1 <<< (wb - 1)) - 1;
    lo = -(1 <<< (wb - 1));
    if (up && (w < hi)) return w + 1;
    if (!up && (w > lo)) return w - 1;
    return w;
  endfunction

  // Bipolar input: a 1 bit passes the weight through, a 0 bit negates it.
  function automatic int bipolar(input logic b, input int w);
    return b ? w : -w;
  endfunction

endpackage

// File: rtl/pbp_table.sv
module pbp_table #(
  parameter int ROWS    = 64,
  parameter int ENTRIES = 17,
  parameter int W_BITS  = 8,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int ROW_W  = ENTRIES * W_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [ROW_W-1:0] rd_a_row,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [ROW_W-1:0] rd_b_row,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_row
);

  logic [ROW_W-1:0] rows_q [ROWS];

  assign rd_a_row = rows_q[rd_a_idx];
  assign rd_b_row = rows_q[rd_b_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
    end else if (wr_en) begin
      rows_q[wr_idx] <= wr_row;
    end
  end

endmodule

// File: rtl/pbp_dot.sv
module pbp_dot #(
  parameter int HIST_LEN = 16,
  parameter int W_BITS   = 8,
  parameter int SUM_W    = 13,
  localparam int ENTRIES = HIST_LEN + 1,
  localparam int ROW_W   = ENTRIES * W_BITS
) (
  input  logic [ROW_W-1:0]    row,
  input  logic [HIST_LEN-1:0] hist,
  output logic [SUM_W-1:0]    sum
);
  import pbp_pkg::*;

  int acc;
  logic signed [W_BITS-1:0] wv;

  always_comb begin
    wv  = row[0 +: W_BITS];
    acc = int'(wv);
    for (int k = 0; k < HIST_LEN; k++) begin
      wv  = row[(k + 1) * W_BITS +: W_BITS];
      acc = acc + bipolar(hist[k], int'(wv));
    end
    sum = acc[SUM_W-1:0];
  end

endmodule

// File: rtl/pbp_update.sv
module pbp_update #(
  parameter int HIST_LEN = 16,
  parameter int W_BITS   = 8,
  parameter int SUM_W    = 13,
  parameter int THETA    = 44,
  localparam int ENTRIES = HIST_LEN + 1,
  localparam int ROW_W   = ENTRIES * W_BITS
) (
  input  logic [ROW_W-1:0]    row_in,
  input  logic [HIST_LEN-1:0] hist,
  input  logic                taken,
  input  logic [SUM_W-1:0]    sum,
  output logic [ROW_W-1:0]    row_out,
  output logic                fire
);
  import pbp_pkg::*;

  logic signed [SUM_W-1:0]  s_sig;
  logic signed [W_BITS-1:0] wv;
  logic                     said_taken;
  logic                     mispredict;
  logic                     up;
  int                       mag;
  int                       nw;

  always_comb begin
    s_sig      = sum;
    said_taken = !s_sig[SUM_W-1];
    mispredict = (said_taken != taken);
    mag        = s_sig[SUM_W-1] ? -int'(s_sig) : int'(s_sig);
    fire       = mispredict || (mag <= THETA);
  end

  always_comb begin
    row_out = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      wv = row_in[e * W_BITS +: W_BITS];
      if (e == 0) up = taken;
      else        up = (hist[e - 1] == taken);
      nw = sat_step(int'(wv), up, W_BITS);
      row_out[e * W_BITS +: W_BITS] = nw[W_BITS-1:0];
    end
  end

endmodule

// File: rtl/perceptron_bp.sv
module perceptron_bp #(
  parameter int HIST_LEN = 16,
  parameter int ROWS     = 64,
  parameter int W_BITS   = 8,
  parameter int PC_W     = 32,
  localparam int SUM_W   = W_BITS + $clog2(HIST_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pred_valid,
  input  logic [PC_W-1:0]     pred_pc,
  output logic                pred_out_valid,
  output logic                pred_taken,
  output logic [SUM_W-1:0]    pred_sum,
  output logic [HIST_LEN-1:0] pred_hist,
  input  logic                train_valid,
  input  logic [PC_W-1:0]     train_pc,
  input  logic                train_taken,
  input  logic [SUM_W-1:0]    train_sum,
  input  logic [HIST_LEN-1:0] train_hist
);
  import pbp_pkg::*;

  localparam int IDX_W   = $clog2(ROWS);
  localparam int ENTRIES = HIST_LEN + 1;
  localparam int ROW_W   = ENTRIES * W_BITS;
  localparam int THETA   = theta_of(HIST_LEN);

  function automatic logic [IDX_W-1:0] row_of(input logic [PC_W-1:0] pc);
    return pc[2 +: IDX_W] ^ pc[2 + IDX_W +: IDX_W];
  endfunction

  logic [HIST_LEN-1:0] hist_q;
  logic [IDX_W-1:0]    p_idx, t_idx;
  logic [ROW_W-1:0]    p_row, t_row, t_row_new;
  logic [SUM_W-1:0]    p_sum;
  logic                t_fire;
  logic                wr_en;

  assign p_idx = row_of(pred_pc);
  assign t_idx = row_of(train_pc);
  assign wr_en = train_valid && t_fire;

  pbp_table #(.ROWS(ROWS), .ENTRIES(ENTRIES), .W_BITS(W_BITS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(p_idx), .rd_a_row(p_row),
    .rd_b_idx(t_idx), .rd_b_row(t_row),
    .wr_en(wr_en), .wr_idx(t_idx), .wr_row(t_row_new)
  );

  pbp_dot #(.HIST_LEN(HIST_LEN), .W_BITS(W_BITS), .SUM_W(SUM_W)) u_dot (
    .row(p_row), .hist(hist_q), .sum(p_sum)
  );

  pbp_update #(.HIST_LEN(HIST_LEN), .W_BITS(W_BITS), .SUM_W(SUM_W), .THETA(THETA)) u_upd (
    .row_in(t_row), .hist(train_hist), .taken(train_taken), .sum(train_sum),
    .row_out(t_row_new), .fire(t_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q         <= '0;
      pred_out_valid <= 1'b0;
      pred_taken     <= 1'b0;
      pred_sum       <= '0;
      pred_hist      <= '0;
    end else begin
      pred_out_valid <= pred_valid;
      if (pred_valid) begin
        pred_sum   <= p_sum;
        pred_taken <= !p_sum[SUM_W-1];
        pred_hist  <= hist_q;
      end
      if (train_valid) hist_q <= {hist_q[HIST_LEN-2:0], train_taken};
    end
  end

  AST_OUT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |=> pred_out_valid); // R5
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |=> !pred_out_valid); // R5
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    train_valid |=> hist_q[0] == $past(train_taken)); // R6
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !train_valid |=> $stable(hist_q)); // R6
  AST_CONFIDENT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (train_valid && (($signed(train_sum) >= 0) == train_taken) &&
     (($signed(train_sum) > THETA) || ($signed(train_sum) < -THETA))) |-> !wr_en); // R7
  AST_SIGN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    pred_out_valid |-> (pred_taken == ($signed(pred_sum) >= 0))); // R4

endmodule

// File: tb/perceptron_bp_test.sv
`timescale 1ns/1ps
module perceptron_bp_test;
  localparam int N  = 16;
  localparam int SW = 13;
  localparam int TH = 44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_valid = 1'b0;
  logic [31:0] pred_pc = '0;
  logic pred_out_valid, pred_taken;
  logic [SW-1:0] pred_sum;
  logic [N-1:0] pred_hist;
  logic train_valid = 1'b0;
  logic [31:0] train_pc = '0;
  logic train_taken = 1'b0;
  logic [SW-1:0] train_sum = '0;
  logic [N-1:0] train_hist = '0;

  always #10 clk = ~clk;

  perceptron_bp uut (
    .clk(clk), .rst_n(rst_n),
    .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken),
    .pred_sum(pred_sum), .pred_hist(pred_hist),
    .train_valid(train_valid), .train_pc(train_pc), .train_taken(train_taken),
    .train_sum(train_sum), .train_hist(train_hist)
  );

  // {pc, outcome}: loop-style branch, alternating branch, always-taken branch
  localparam logic [32:0] VEC [16] = '{
    {32'h0000_1040, 1'b1}, {32'h0000_2200, 1'b1}, {32'h0000_1040, 1'b1}, {32'h0000_3A7C, 1'b1},
    {32'h0000_1040, 1'b1}, {32'h0000_2200, 1'b0}, {32'h0000_1040, 1'b0}, {32'h0000_3A7C, 1'b1},
    {32'h0000_1040, 1'b1}, {32'h0000_2200, 1'b1}, {32'h0000_1040, 1'b1}, {32'h0000_3A7C, 1'b1},
    {32'h0000_1040, 1'b1}, {32'h0000_2200, 1'b0}, {32'h0000_1040, 1'b0}, {32'h0000_3A7C, 1'b1}
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int wt [64][N+1];
  logic [N-1:0] mhist;

  function automatic int row_idx(input logic [31:0] pc);
    return int'((pc >> 2) & 32'h3F) ^ int'((pc >> 8) & 32'h3F);
  endfunction

  function automatic int model_sum(input logic [31:0] pc, input logic [N-1:0] h);
    int r, s;
    r = row_idx(pc);
    s = wt[r][0];
    for (int k = 0; k < N; k++) s += (h[k] == 1'b1) ? wt[r][k+1] : -wt[r][k+1];
    return s;
  endfunction

  function automatic void model_train(input logic [31:0] pc, input logic t, input int s, input logic [N-1:0] h);
    int r;
    bit wrong;
    int mag;
    r = row_idx(pc);
    wrong = ((s >= 0) ? 1'b1 : 1'b0) != t;
    mag = (s < 0) ? -s : s;
    if (wrong || mag <= TH) begin
      for (int e = 0; e <= N; e++) begin
        bit inc;
        inc = (e == 0) ? t : (h[e-1] == t);
        if (inc) begin if (wt[r][e] < 127) wt[r][e]++; end
        else begin if (wt[r][e] > -128) wt[r][e]--; end
      end
    end
    mhist = {mhist[N-2:0], t};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_predict(input logic [31:0] pc);
    @(negedge clk);
    pred_valid = 1'b1; pred_pc = pc;
    @(negedge clk);
    pred_valid = 1'b0;
  endtask

  task automatic do_train(input logic [31:0] pc, input logic t, input int s, input logic [N-1:0] h);
    @(negedge clk);
    train_valid = 1'b1; train_pc = pc; train_taken = t;
    train_sum = SW'(s); train_hist = h;
    @(negedge clk);
    train_valid = 1'b0;
    model_train(pc, t, s, h);
  endtask

  task automatic pred_check(input logic [31:0] pc, input string req, output int s_out, output logic [N-1:0] h_out);
    int es;
    es = model_sum(pc, mhist);
    do_predict(pc);
    chk({req, " valid"}, int'(pred_out_valid), 1);
    chk({req, " sum"}, int'($signed(pred_sum)), es);
    chk({req, " dir"}, int'(pred_taken), (es >= 0) ? 1 : 0);
    chk({req, " hist"}, int'(pred_hist), int'(mhist));
    s_out = int'($signed(pred_sum));
    h_out = pred_hist;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int s, s0;
    logic [N-1:0] h;
    for (int r = 0; r < 64; r++) for (int e = 0; e <= N; e++) wt[r][e] = 0;
    mhist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 R5 no output after reset", int'(pred_out_valid), 0);

    // R1: zero state gives sum 0, taken, history 0
    do_predict(32'h0000_0000);
    chk("R1 sum", int'($signed(pred_sum)), 0);
    chk("R1 R4 dir", int'(pred_taken), 1);
    chk("R1 hist", int'(pred_hist), 0);
    @(negedge clk);
    chk("R5 valid drops", int'(pred_out_valid), 0);

    // R3 R4 R6 R8: vector walk
    for (int pass = 0; pass < 8; pass++) begin
      for (int i = 0; i < 16; i++) begin
        pred_check(VEC[i][32:1], "R3 R4 R6 R8", s, h);
        do_train(VEC[i][32:1], VEC[i][0], s, h);
      end
    end

    // R2: 0x004 and 0x100 hash to the same row
    pred_check(32'h0000_0004, "R2 pre", s, h);
    do_train(32'h0000_0004, 1'b0, 0, h);
    pred_check(32'h0000_0100, "R2 alias", s, h);
    chk("R2 row shared", row_idx(32'h4), row_idx(32'h100));

    // R7: confident correct sum 45 leaves row untouched, 44 trains
    pred_check(32'h0000_0500, "R7 base", s0, h);
    do_train(32'h0000_0500, 1'b1, 45, h);
    pred_check(32'h0000_0500, "R7 skip", s, h);
    do_train(32'h0000_0500, 1'b1, 44, h);
    pred_check(32'h0000_0500, "R7 R8 boundary", s, h);

    // R9: drive to upper saturation
    for (int i = 0; i < 200; i++) do_train(32'h0000_0800, 1'b1, -1, mhist);
    pred_check(32'h0000_0800, "R9 upper", s, h);
    chk("R9 max sum", s, 17 * 127);
    for (int i = 0; i < 300; i++) do_train(32'h0000_0800, 1'b0, 0, mhist);
    pred_check(32'h0000_0800, "R9 lower", s, h);
    chk("R9 min sum", s, -128 - 16 * 127);

    // R10: simultaneous predict and train on one row
    s = model_sum(32'h0000_0800, mhist);
    h = mhist;
    @(negedge clk);
    pred_valid = 1'b1; pred_pc = 32'h0000_0800;
    train_valid = 1'b1; train_pc = 32'h0000_0800; train_taken = 1'b1;
    train_sum = SW'(-5); train_hist = mhist;
    @(negedge clk);
    pred_valid = 1'b0; train_valid = 1'b0;
    chk("R10 sum before train", int'($signed(pred_sum)), s);
    chk("R10 hist before train", int'(pred_hist), int'(h));
    model_train(32'h0000_0800, 1'b1, -5, h);
    pred_check(32'h0000_0800, "R10 after", s, h);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule